// File: doc/BRIEF.md
# Read Response Frame Builder

This block answers a memory-read request of a serial bootloader. When it is told to start, it takes a start address and a byte count. It then reads that many bytes from a simple synchronous memory port, one byte per strobe, with read data returned one cycle after the strobe. It sends out a complete response frame, one byte at a time, on a transmit interface that uses valid/ready handshaking. Request parsing and the bit timing of the serial line belong to other blocks.

The frame has these parts, in order:
- a fixed header byte of 0x80;
- a filler byte driven as 0x00;
- the byte count, sent twice;
- the data bytes, taken from consecutive addresses;
- a two-byte checksum, low byte first.

The low checksum byte is the inverted XOR of the bytes at odd positions (1st, 3rd, ...), counted from the header. The high checksum byte is the inverted XOR of the bytes at even positions. No acknowledge byte follows the frame. Reading 14 bytes, for example, gives a frame that opens 80 00 0E 0E.

The controller is one state machine with these states:
- `S_IDLE`: waits for a start.
- `S_REJECT`: a one-cycle error state, entered from `S_IDLE` on a start whose count is out of range.
- `S_HDR`, `S_FILL`, `S_LEN_A`, `S_LEN_B`: send the fixed part of the frame.
- `S_RD_REQ`: issues one memory read.
- `S_RD_WAIT`: captures the returned byte.
- `S_DATA`: offers the captured byte.
- `S_CK_LO`, `S_CK_HI`: send the checksum bytes.
- `S_FIN`: a one-cycle completion state.

The transitions are:
- Every transmit state moves to the next state once its byte is accepted.
- `S_LEN_B` moves to `S_RD_REQ`.
- `S_RD_REQ` always moves to `S_RD_WAIT`, and `S_RD_WAIT` always moves to `S_DATA`.
- `S_DATA` returns to `S_RD_REQ` while bytes remain. After the last data byte it moves to `S_CK_LO`.
- `S_CK_HI` moves to `S_FIN`.
- `S_FIN` and `S_REJECT` return to `S_IDLE`.

Top module: `read_frame_tx`

## Requirements
- R1: After reset, `tx_valid_o`, `mem_rd_o`, `done_o` and `err_o` are all 0.
- R2: An accepted request sends these bytes in order: 0x80, then 0x00, then the count, then the count again, then the data bytes, then the low checksum byte, then the high checksum byte. Nothing else is sent.
- R3: Data byte k (counting from 0) is the memory byte at address `addr_i + k`, taken modulo 2^ADDR_W.
- R4: The low checksum byte is the inverse of the XOR of the frame bytes at positions 1, 3, 5, and so on. The high checksum byte is the inverse of the XOR of the bytes at positions 2, 4, 6, and so on. Position 1 is the header, and the checksum bytes themselves are excluded.
- R5: Each read strobe lasts one cycle. No strobe is raised while a transmit byte is pending. Exactly as many reads are issued as the request count.
- R6: `done_o` is high for exactly one cycle, the cycle after the high checksum byte is accepted.
- R7: A start with a count of 0 or more than 250 raises `err_o` for one cycle, in the cycle after the start. Such a start sends no byte and issues no read.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` stay unchanged into the next cycle.
- R9: A start that arrives while a frame is in progress has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled in `S_IDLE` |
| addr_i | input | ADDR_W | First memory address to read |
| len_i | input | LEN_W | Number of data bytes |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the strobe |
| tx_data_o | output | 8 | Outgoing frame byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| err_o | output | 1 | One-cycle pulse when a request is refused |

## Verification
The assertions assume the following about the inputs:
- the memory returns data exactly one cycle after each strobe;
- `tx_ready_i` is a plain level that may change in any cycle;
- `start_i` may be asserted at any time.

The bench drives all inputs half a cycle away from the clock edge. It models the memory as a registered function of the address, so the one-cycle read latency holds by construction. It varies `tx_ready_i` in several fixed patterns, including long stalls, so that the hold behaviour and the read spacing are exercised. It also pulses `start_i` in the middle of a frame to test that such a start is ignored.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_REJECT,
        S_HDR,
        S_FILL,
        S_LEN_A,
        S_LEN_B,
        S_RD_REQ,
        S_RD_WAIT,
        S_DATA,
        S_CK_LO,
        S_CK_HI,
        S_FIN
    } rrf_state_t;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/rrf_len_gate.sv
module rrf_len_gate #(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned MAX_LEN = 250
) (
    input  logic [LEN_W-1:0] len_i,
    output logic             ok_o
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

    always_comb begin
        ok_o = (len_i != '0) && (len_i <= LIMIT);
    end
endmodule

// File: rtl/rrf_addr_seq.sv
module rrf_addr_seq #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
            left_q <= len_i;
        end else if (step_i) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - ONE;
        end
    end

    assign addr_o = addr_q;
    assign last_o = (left_q == ONE);
endmodule

// File: rtl/rrf_cksum.sv
module rrf_cksum #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] ck_lo_o,
    output logic [BYTE_W-1:0] ck_hi_o
);
    logic [BYTE_W-1:0] acc_odd_q;
    logic [BYTE_W-1:0] acc_even_q;
    logic              even_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_odd_q  <= '0;
            acc_even_q <= '0;
            even_q     <= 1'b0;
        end else if (clear_i) begin
            acc_odd_q  <= '0;
            acc_even_q <= '0;
            even_q     <= 1'b0;
        end else if (take_i) begin
            if (even_q) begin
                acc_even_q <= acc_even_q ^ byte_i;
            end else begin
                acc_odd_q  <= acc_odd_q ^ byte_i;
            end
            even_q <= ~even_q;
        end
    end

    assign ck_lo_o = ~acc_odd_q;
    assign ck_hi_o = ~acc_even_q;
endmodule

// File: rtl/read_frame_tx.sv
module read_frame_tx #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned MAX_LEN   = 250,
    parameter logic [7:0]  HDR_BYTE  = 8'h80,
    parameter logic [7:0]  FILL_BYTE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              done_o,
    output logic              err_o
);
    import rrf_pkg::*;

    rrf_state_t state_q, state_d;

    logic             len_ok;
    logic             accept;
    logic             fire;
    logic             last;
    logic             sum_take;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       data_q;
    logic [7:0]       ck_lo;
    logic [7:0]       ck_hi;

    rrf_len_gate #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len_gate (
        .len_i (len_i),
        .ok_o  (len_ok)
    );

    assign accept = (state_q == S_IDLE) && start_i && len_ok;
    assign fire   = tx_valid_o && tx_ready_i;

    rrf_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .addr_i (addr_i),
        .len_i  (len_i),
        .step_i (fire && (state_q == S_DATA)),
        .addr_o (mem_addr_o),
        .last_o (last)
    );

    always_comb begin
        sum_take = 1'b0;
        unique case (state_q)
            S_HDR, S_FILL, S_LEN_A, S_LEN_B, S_DATA: sum_take = fire;
            default:                                 sum_take = 1'b0;
        endcase
    end

    rrf_cksum #(.BYTE_W(BYTE_W)) u_cksum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .take_i  (sum_take),
        .byte_i  (tx_data_o),
        .ck_lo_o (ck_lo),
        .ck_hi_o (ck_hi)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                len_q <= len_i;
            end
            if (state_q == S_RD_WAIT) begin
                data_q <= mem_rdata_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = len_ok ? S_HDR : S_REJECT;
                end
            end
            S_REJECT:  state_d = S_IDLE;
            S_HDR:     if (fire) state_d = S_FILL;
            S_FILL:    if (fire) state_d = S_LEN_A;
            S_LEN_A:   if (fire) state_d = S_LEN_B;
            S_LEN_B:   if (fire) state_d = S_RD_REQ;
            S_RD_REQ:  state_d = S_RD_WAIT;
            S_RD_WAIT: state_d = S_DATA;
            S_DATA: begin
                if (fire) begin
                    state_d = last ? S_CK_LO : S_RD_REQ;
                end
            end
            S_CK_LO:   if (fire) state_d = S_CK_HI;
            S_CK_HI:   if (fire) state_d = S_FIN;
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid_o = 1'b0;
        tx_data_o  = 8'h00;
        mem_rd_o   = 1'b0;
        done_o     = 1'b0;
        err_o      = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_REJECT:  err_o = 1'b1;
            S_HDR: begin
                tx_valid_o = 1'b1;
                tx_data_o  = HDR_BYTE;
            end
            S_FILL: begin
                tx_valid_o = 1'b1;
                tx_data_o  = FILL_BYTE;
            end
            S_LEN_A, S_LEN_B: begin
                tx_valid_o = 1'b1;
                tx_data_o  = 8'(len_q);
            end
            S_RD_REQ:  mem_rd_o = 1'b1;
            S_RD_WAIT: ;
            S_DATA: begin
                tx_valid_o = 1'b1;
                tx_data_o  = data_q;
            end
            S_CK_LO: begin
                tx_valid_o = 1'b1;
                tx_data_o  = ck_lo;
            end
            S_CK_HI: begin
                tx_valid_o = 1'b1;
                tx_data_o  = ck_hi;
            end
            S_FIN:     done_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/read_frame_tx_checker.sv
module read_frame_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rd_o,
    input logic [7:0] tx_data_o,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic       done_o,
    input logic       err_o
);
    // R8: a byte that is not yet taken stays on the bus, unchanged
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R5: a read is never issued while a byte is pending
    p_rd_idle_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> !tx_valid_o);

    // R5: each read strobe lasts one cycle
    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done follows a byte that was accepted in the previous cycle
    p_done_after_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tx_valid_o && tx_ready_i));

    // R7: a refusal sends nothing and reads nothing
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!tx_valid_o && !mem_rd_o && !done_o));

    // R7: the error flag is a single-cycle pulse
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
endmodule

bind read_frame_tx read_frame_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd_o   (mem_rd_o),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/read_frame_tx_tb.sv
module read_frame_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  len_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i = 1'b0;
    logic        done_o;
    logic        err_o;

    int checks = 0;
    int fails = 0;
    int reads = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    read_frame_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .len_i       (len_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_rdata_i (mem_rdata_i),
        .tx_data_o   (tx_data_o),
        .tx_valid_o  (tx_valid_o),
        .tx_ready_i  (tx_ready_i),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (mem_rd_o) begin
            mem_rdata_i <= mem_f(mem_addr_o);
            reads++;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one frame request and compares the received frame with the expected one.
    // Ready modes: 0 = always high, 1 = alternating, 2 = high one cycle in three, 3 = long stalls.
    task automatic run_frame(input logic [15:0] a, input int n, input int mode, input bit disturb);
        logic [7:0] got[$];
        logic [7:0] exp[$];
        logic [7:0] lo;
        logic [7:0] hi;
        int dones = 0;
        int cyc = 0;
        bit finished = 0;
        reads = 0;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; len_i = 8'(n);
        @(negedge clk);
        start_i = 1'b0;
        while (!finished && cyc < 4000) begin
            case (mode)
                0: tx_ready_i = 1'b1;
                1: tx_ready_i = cyc[0];
                2: tx_ready_i = (cyc % 3) == 2;
                default: tx_ready_i = (cyc % 11) > 7;
            endcase
            if (disturb && cyc == 9) begin
                start_i = 1'b1; addr_i = a + 16'h0100; len_i = 8'd3;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (done_o) begin
                dones++;
                finished = 1;
            end
            if (tx_valid_o && tx_ready_i) got.push_back(tx_data_o);
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        tx_ready_i = 1'b0;
        // one more cycle: done must have dropped and nothing more sent
        #1;
        check("R6", int'(done_o), 0, "done low after pulse");
        check("R2", int'(tx_valid_o), 0, "no byte after frame");
        check("R6", dones, 1, "done pulses");
        exp.push_back(8'h80);
        exp.push_back(8'h00);
        exp.push_back(8'(n));
        exp.push_back(8'(n));
        for (int k = 0; k < n; k++) exp.push_back(mem_f(a + 16'(k)));
        lo = 8'h00; hi = 8'h00;
        for (int k = 0; k < exp.size(); k++) begin
            if (k % 2 == 0) lo ^= exp[k]; else hi ^= exp[k];
        end
        exp.push_back(~lo);
        exp.push_back(~hi);
        check("R2", got.size(), exp.size(), "frame length");
        for (int k = 0; k < exp.size() && k < got.size(); k++) begin
            if (k < 4) check("R2", got[k], exp[k], $sformatf("byte %0d", k));
            else if (k < 4 + n) check(disturb ? "R9" : "R3", got[k], exp[k], $sformatf("data %0d", k - 4));
            else check("R4", got[k], exp[k], $sformatf("checksum byte %0d", k - 4 - n));
        end
        check("R5", reads, n, "read count");
    endtask

    task automatic run_reject(input int n);
        int seen = 0;
        reads = 0;
        @(negedge clk);
        start_i = 1'b1; addr_i = 16'h1234; len_i = 8'(n); tx_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check("R7", int'(err_o), 1, $sformatf("err for length %0d", n));
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            if (tx_valid_o || err_o || done_o) seen++;
        end
        check("R7", seen, 0, "no frame or repeat err after refusal");
        check("R7", reads, 0, "no reads after refusal");
        tx_ready_i = 1'b0;
    endtask

    task automatic test_reset();
        #1;
        check("R1", int'(tx_valid_o), 0, "tx_valid in reset");
        check("R1", int'(mem_rd_o), 0, "mem_rd in reset");
        check("R1", int'(done_o), 0, "done in reset");
        check("R1", int'(err_o), 0, "err in reset");
    endtask

    initial begin
        begin : wd
            fork
                begin
                    wait (cycles > 150000);
                    fails++;
                    checks++;
                    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                end
                begin
                    repeat (3) @(negedge clk);
                    test_reset();
                    rst_n = 1'b1;
                    @(negedge clk);
                    test_reset();
                    run_frame(16'h0F00, 14, 0, 0);   // R2 R3 R4 sample request
                    run_frame(16'h2001, 1, 1, 0);    // single byte, odd total
                    run_frame(16'hFFF8, 20, 2, 0);   // R3 address wrap
                    run_frame(16'h4000, 250, 3, 0);  // largest count, R8 stalls
                    run_frame(16'h0300, 7, 1, 1);    // R9 start mid frame
                    run_reject(0);
                    run_reject(251);
                    run_reject(255);
                    run_frame(16'h0010, 2, 0, 0);    // recovers after refusals
                end
            join_any
            disable fork;
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule